// File: doc/BRIEF.md
# Per-Pin Timed-Event Drive Generator

This block produces the drive signal for a single tester pin. A fast clock splits every tester cycle into a fixed number of tick slots. A small store inside the block holds several waveforms that the user defines. Each waveform is a short list of event slots. Each slot pairs a tick position with an action, and that action sets the pin's drive level and drive enable. At the start of every tester cycle a selector input names one waveform. The block then applies that waveform's events at their ticks. Nothing moves between events: the pin keeps its state from one tick to the next and across cycle boundaries.

A waveform is changed one event slot at a time through a write port. A write does not take effect at once. It passes through a short fixed pipeline. While a write to a waveform is in that pipeline, the waveform is in a dead zone: selecting it leaves the pin untouched. Several events may sit in one cycle, so the same drive action can fire more than once in a single tester cycle.

Top module: `wfg_pin_gen`

## Requirements
- R1: While reset is asserted and after it is released, drive_en and drive_lvl are 0 and every event slot is invalid, so the pin stays undriven until events are written.
- R2: A tester cycle is TICKS clocks long and starts at the first clock after reset. wf_sel is captured at tick 0 of each cycle and names the waveform for that whole cycle, including its tick 0 events. Changes to wf_sel at other ticks have no effect.
- R3: A valid event with tick t in the selected waveform takes effect on the clock edge that ends tick t. Its result is visible on the outputs from then on.
- R4: Action codes are 0 for hold (no change), 1 for drive low (en=1, lvl=0), 2 for drive high (en=1, lvl=1) and 3 for drive off (en=0, lvl kept).
- R5: Several events can fire within one cycle. The output state persists across cycle boundaries until an event changes it.
- R6: When two valid events in one waveform share a tick, the one in the higher slot index decides the result.
- R7: A slot written with wr_valid=0 never acts, whatever its tick and action.
- R8: An event whose tick is TICKS or more (tick field is clog2(TICKS)+1 bits wide) never acts.
- R9: A write accepted on a clock edge updates the store WR_LAT (default 2) edges later. At every edge before that update, and at the edge of the update itself, events of the waveform being written are suppressed and the pin holds.
- R10: A write pending for one waveform does not disturb the events of a different selected waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wf_sel | input | SEL_W | Waveform chosen for the cycle, taken at tick 0 |
| wr_en | input | 1 | Write one event slot |
| wr_wf | input | SEL_W | Waveform being written |
| wr_slot | input | SLOT_W | Event slot being written |
| wr_valid | input | 1 | Validity of the written slot |
| wr_tick | input | TICK_W | Tick position of the written event |
| wr_act | input | 2 | Action code of the written event |
| drive_lvl | output | 1 | Drive level |
| drive_en | output | 1 | Drive enable |

## Verification
The bench goes after the tick 0 boundary, where wf_sel must pass straight through. A design that used the previous cycle's selection there would fire the wrong waveform's tick 0 event, or apply a late change of the selector in the middle of a cycle. Colliding events at the same tick are checked so that a reversed priority shows up as the wrong level. Ticks beyond the cycle and slots marked invalid are checked so that a truncated comparison or a lost valid bit shows up as a spurious edge. The write dead zone is probed on exactly the edges around the update. An off-by-one latency, suppression applied to the wrong waveform, or no suppression at all each lets an event through, or blocks one, on a specific tick.

// File: rtl/wfg_pkg.sv
package wfg_pkg;
    // Drive actions an event can carry; code values are visible on wr_act.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOW  = 2'd1,
        ACT_HIGH = 2'd2,
        ACT_OFF  = 2'd3
    } wfg_act_e;

    // Width of an event's tick field: one bit beyond the counter so that
    // positions past the end of the cycle can be expressed.
    function automatic int wfg_tick_w(input int ticks);
        return $clog2(ticks) + 1;
    endfunction
endpackage

// File: rtl/wfg_tick_ctr.sv
// Tick counter and selector capture.
// Counts TICKS clocks per tester cycle, starting at tick 0 right after reset.
// The selector is registered at tick 0; at tick 0 itself the live input is
// used so that events on the first tick already follow the new choice.
// Assumes TICKS >= 2.
module wfg_tick_ctr #(
    parameter int NUM_WF = 4,
    parameter int TICKS  = 16,
    localparam int SEL_W = $clog2(NUM_WF),
    localparam int CNT_W = $clog2(TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] wf_sel,
    output logic [CNT_W-1:0] tick_q,
    output logic [SEL_W-1:0] sel_q,
    output logic [SEL_W-1:0] eff_sel
);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(TICKS - 1);

    logic at_start;

    // Start-of-cycle flag from the counter.
    always_comb at_start = (tick_q == '0);

    // Advance the tick position, wrapping at the end of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 tick_q <= '0;
        else if (tick_q == LAST_TICK) tick_q <= '0;
        else                        tick_q <= tick_q + 1'b1;
    end

    // Hold the cycle's waveform choice from tick 0 onward.
    always_ff @(posedge clk) begin
        if (!rst_n)        sel_q <= '0;
        else if (at_start) sel_q <= wf_sel;
    end

    // Selection in force at the current tick.
    always_comb eff_sel = at_start ? wf_sel : sel_q;
endmodule

// File: rtl/wfg_event_store.sv
// Event storage with delayed write commit.
// Holds NUM_WF waveforms of NUM_EV event slots each in flops and reads one
// waveform combinationally. A write passes through WR_LAT pipeline stages
// before it lands; while any stage holds a write to the waveform being read,
// busy is raised so the caller can suppress it.
// Assumes NUM_EV >= 2 and WR_LAT >= 1.
module wfg_event_store #(
    parameter int NUM_WF = 4,
    parameter int NUM_EV = 4,
    parameter int TICKS  = 16,
    parameter int WR_LAT = 2,
    localparam int SEL_W  = $clog2(NUM_WF),
    localparam int SLOT_W = $clog2(NUM_EV),
    localparam int TICK_W = wfg_pkg::wfg_tick_w(TICKS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [SEL_W-1:0]               wr_wf,
    input  logic [SLOT_W-1:0]              wr_slot,
    input  logic                           wr_valid,
    input  logic [TICK_W-1:0]              wr_tick,
    input  logic [1:0]                     wr_act,
    input  logic [SEL_W-1:0]               rd_sel,
    output logic [NUM_EV-1:0]              rd_valid,
    output logic [NUM_EV-1:0][TICK_W-1:0]  rd_tick,
    output logic [NUM_EV-1:0][1:0]         rd_act,
    output logic                           busy
);
    localparam int LST = WR_LAT - 1;

    logic [NUM_WF-1:0][NUM_EV-1:0]             mem_valid;
    logic [NUM_WF-1:0][NUM_EV-1:0][TICK_W-1:0] mem_tick;
    logic [NUM_WF-1:0][NUM_EV-1:0][1:0]        mem_act;

    logic [WR_LAT-1:0]              st_v;
    logic [WR_LAT-1:0][SEL_W-1:0]   st_wf;
    logic [WR_LAT-1:0][SLOT_W-1:0]  st_slot;
    logic [WR_LAT-1:0]              st_valid;
    logic [WR_LAT-1:0][TICK_W-1:0]  st_tick;
    logic [WR_LAT-1:0][1:0]         st_act;

    // First pipeline stage captures the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_v[0] <= 1'b0;
        end else begin
            st_v[0] <= wr_en;
        end
        st_wf[0]    <= wr_wf;
        st_slot[0]  <= wr_slot;
        st_valid[0] <= wr_valid;
        st_tick[0]  <= wr_tick;
        st_act[0]   <= wr_act;
    end

    // Later pipeline stages, one per extra cycle of write latency.
    for (genvar s = 1; s < WR_LAT; s++) begin : g_stage
        // Shift the pending write one stage further.
        always_ff @(posedge clk) begin
            if (!rst_n) st_v[s] <= 1'b0;
            else        st_v[s] <= st_v[s-1];
            st_wf[s]    <= st_wf[s-1];
            st_slot[s]  <= st_slot[s-1];
            st_valid[s] <= st_valid[s-1];
            st_tick[s]  <= st_tick[s-1];
            st_act[s]   <= st_act[s-1];
        end
    end

    // Commit the oldest pending write into the store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_valid <= '0;
            mem_tick  <= '0;
            mem_act   <= '0;
        end else if (st_v[LST]) begin
            mem_valid[st_wf[LST]][st_slot[LST]] <= st_valid[LST];
            mem_tick[st_wf[LST]][st_slot[LST]]  <= st_tick[LST];
            mem_act[st_wf[LST]][st_slot[LST]]   <= st_act[LST];
        end
    end

    // Read out the selected waveform.
    always_comb begin
        rd_valid = mem_valid[rd_sel];
        rd_tick  = mem_tick[rd_sel];
        rd_act   = mem_act[rd_sel];
    end

    // Flag the dead zone of the selected waveform.
    always_comb begin
        busy = 1'b0;
        for (int s = 0; s < WR_LAT; s++) begin
            if (st_v[s] && (st_wf[s] == rd_sel)) busy = 1'b1;
        end
    end
endmodule

// File: rtl/wfg_event_exec.sv
// Event matcher and action resolver.
// Compares every slot of the selected waveform against the current tick and
// folds matching actions in ascending slot order, so the highest matching
// slot decides. Nothing matches while busy is raised.
module wfg_event_exec #(
    parameter int NUM_EV = 4,
    parameter int TICKS  = 16,
    localparam int CNT_W  = $clog2(TICKS),
    localparam int TICK_W = wfg_pkg::wfg_tick_w(TICKS)
) (
    input  logic [CNT_W-1:0]              tick_q,
    input  logic [NUM_EV-1:0]             ev_valid,
    input  logic [NUM_EV-1:0][TICK_W-1:0] ev_tick,
    input  logic [NUM_EV-1:0][1:0]        ev_act,
    input  logic                          busy,
    input  logic                          cur_lvl,
    input  logic                          cur_en,
    output logic                          nxt_lvl,
    output logic                          nxt_en,
    output logic                          hit_any
);
    import wfg_pkg::*;

    logic [NUM_EV-1:0] hit;

    // Per-slot tick match; ticks past the cycle never equal the counter.
    always_comb begin
        for (int e = 0; e < NUM_EV; e++) begin
            hit[e] = !busy && ev_valid[e] && (ev_tick[e] == {1'b0, tick_q});
        end
    end

    // Fold matching actions onto the current drive state.
    always_comb begin
        nxt_lvl = cur_lvl;
        nxt_en  = cur_en;
        for (int e = 0; e < NUM_EV; e++) begin
            if (hit[e]) begin
                case (wfg_act_e'(ev_act[e]))
                    ACT_LOW:  begin nxt_en = 1'b1; nxt_lvl = 1'b0; end
                    ACT_HIGH: begin nxt_en = 1'b1; nxt_lvl = 1'b1; end
                    ACT_OFF:  nxt_en = 1'b0;
                    default:  ;
                endcase
            end
        end
    end

    // Any slot firing at this tick.
    always_comb hit_any = |hit;
endmodule

// File: rtl/wfg_pin_gen.sv
// Per-pin timed-event drive generator (top).
// Ties together the tick counter, the event store and the matcher, and keeps
// the registered drive state. Drive state changes only on an event edge.
// Assumes NUM_WF and NUM_EV are powers of two, NUM_EV >= 2.
module wfg_pin_gen #(
    parameter int NUM_WF = 4,
    parameter int NUM_EV = 4,
    parameter int TICKS  = 16,
    parameter int WR_LAT = 2,
    localparam int SEL_W  = $clog2(NUM_WF),
    localparam int SLOT_W = $clog2(NUM_EV),
    localparam int CNT_W  = $clog2(TICKS),
    localparam int TICK_W = wfg_pkg::wfg_tick_w(TICKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  wf_sel,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_wf,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_valid,
    input  logic [TICK_W-1:0] wr_tick,
    input  logic [1:0]        wr_act,
    output logic              drive_lvl,
    output logic              drive_en
);
    logic [CNT_W-1:0]              tick_q;
    logic [SEL_W-1:0]              sel_q;
    logic [SEL_W-1:0]              eff_sel;
    logic [NUM_EV-1:0]             ev_valid;
    logic [NUM_EV-1:0][TICK_W-1:0] ev_tick;
    logic [NUM_EV-1:0][1:0]        ev_act;
    logic                          busy;
    logic                          hit_any;
    logic                          nxt_lvl;
    logic                          nxt_en;

    wfg_tick_ctr #(.NUM_WF(NUM_WF), .TICKS(TICKS)) tick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wf_sel  (wf_sel),
        .tick_q  (tick_q),
        .sel_q   (sel_q),
        .eff_sel (eff_sel)
    );

    wfg_event_store #(
        .NUM_WF(NUM_WF), .NUM_EV(NUM_EV), .TICKS(TICKS), .WR_LAT(WR_LAT)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_wf    (wr_wf),
        .wr_slot  (wr_slot),
        .wr_valid (wr_valid),
        .wr_tick  (wr_tick),
        .wr_act   (wr_act),
        .rd_sel   (eff_sel),
        .rd_valid (ev_valid),
        .rd_tick  (ev_tick),
        .rd_act   (ev_act),
        .busy     (busy)
    );

    wfg_event_exec #(.NUM_EV(NUM_EV), .TICKS(TICKS)) exec_i (
        .tick_q   (tick_q),
        .ev_valid (ev_valid),
        .ev_tick  (ev_tick),
        .ev_act   (ev_act),
        .busy     (busy),
        .cur_lvl  (drive_lvl),
        .cur_en   (drive_en),
        .nxt_lvl  (nxt_lvl),
        .nxt_en   (nxt_en),
        .hit_any  (hit_any)
    );

    // Registered drive state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_lvl <= 1'b0;
            drive_en  <= 1'b0;
        end else begin
            drive_lvl <= nxt_lvl;
            drive_en  <= nxt_en;
        end
    end
endmodule

// File: rtl/wfg_pin_gen_chk.sv
// Property checker for the drive generator, bound to every instance.
module wfg_pin_gen_chk #(
    parameter int TICKS = 16,
    parameter int SEL_W = 2,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] tick_q,
    input logic [SEL_W-1:0] sel_q,
    input logic             hit_any,
    input logic             busy,
    input logic             drive_lvl,
    input logic             drive_en
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!drive_en && !drive_lvl));

    // R2
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q == CNT_W'(TICKS - 1)) |=> (tick_q == '0));

    // R2
    sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q != '0) |=> $stable(sel_q));

    // R3
    quiet_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_any |=> $stable({drive_lvl, drive_en}));

    // R9
    dead_zone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({drive_lvl, drive_en}));
endmodule

bind wfg_pin_gen wfg_pin_gen_chk #(
    .TICKS(TICKS), .SEL_W(SEL_W), .CNT_W(CNT_W)
) chk_i (.*);

// File: tb/wfg_pin_gen_tb.sv
`timescale 1ns/1ps
module wfg_pin_gen_tb_top;
    localparam int NUM_WF = 4;
    localparam int NUM_EV = 4;
    localparam int TICKS  = 16;
    localparam int WR_LAT = 2;
    localparam int TICK_W = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wf_sel = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_wf = '0;
    logic [1:0]  wr_slot = '0;
    logic        wr_valid = 1'b0;
    logic [TICK_W-1:0] wr_tick = '0;
    logic [1:0]  wr_act = '0;
    logic        drive_lvl;
    logic        drive_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    string tag  = "R1";

    // Model state built from the requirements.
    int m_tc, m_selq;
    bit m_en, m_lvl;
    bit mv [NUM_WF][NUM_EV];
    int mt [NUM_WF][NUM_EV];
    int ma [NUM_WF][NUM_EV];
    bit pv [WR_LAT];
    int pwf [WR_LAT];
    int psl [WR_LAT];
    bit pvl [WR_LAT];
    int ptk [WR_LAT];
    int pac [WR_LAT];

    wfg_pin_gen #(.NUM_WF(NUM_WF), .NUM_EV(NUM_EV), .TICKS(TICKS), .WR_LAT(WR_LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .wf_sel(wf_sel), .wr_en(wr_en), .wr_wf(wr_wf),
        .wr_slot(wr_slot), .wr_valid(wr_valid), .wr_tick(wr_tick), .wr_act(wr_act),
        .drive_lvl(drive_lvl), .drive_en(drive_en)
    );

    always #2.5 clk = ~clk;

    task automatic check_out(input bit exp_en, input bit exp_lvl);
        n_tests++;
        if (drive_en !== exp_en || drive_lvl !== exp_lvl) begin
            n_fail++;
            $display("FAIL %s: en/lvl got %0b/%0b expected %0b/%0b", tag,
                     drive_en, drive_lvl, exp_en, exp_lvl);
        end
    endtask

    // Predict the effect of the coming clock edge (R2 R3 R4 R6 R7 R8 R9 R10).
    task automatic model_edge();
        int eff = (m_tc == 0) ? int'(wf_sel) : m_selq;
        bit busy = 0;
        for (int i = 0; i < WR_LAT; i++) if (pv[i] && pwf[i] == eff) busy = 1;
        if (!busy) begin
            for (int e = 0; e < NUM_EV; e++) begin
                if (mv[eff][e] && mt[eff][e] == m_tc) begin
                    case (ma[eff][e])
                        1: begin m_en = 1; m_lvl = 0; end
                        2: begin m_en = 1; m_lvl = 1; end
                        3: m_en = 0;
                        default: ;
                    endcase
                end
            end
        end
        if (m_tc == 0) m_selq = eff;
        m_tc = (m_tc + 1) % TICKS;
        if (pv[WR_LAT-1]) begin
            mv[pwf[WR_LAT-1]][psl[WR_LAT-1]] = pvl[WR_LAT-1];
            mt[pwf[WR_LAT-1]][psl[WR_LAT-1]] = ptk[WR_LAT-1];
            ma[pwf[WR_LAT-1]][psl[WR_LAT-1]] = pac[WR_LAT-1];
        end
        for (int i = WR_LAT - 1; i > 0; i--) begin
            pv[i] = pv[i-1]; pwf[i] = pwf[i-1]; psl[i] = psl[i-1];
            pvl[i] = pvl[i-1]; ptk[i] = ptk[i-1]; pac[i] = pac[i-1];
        end
        pv[0] = wr_en; pwf[0] = wr_wf; psl[0] = wr_slot;
        pvl[0] = wr_valid; ptk[0] = wr_tick; pac[0] = wr_act;
    endtask

    task automatic step();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        check_out(m_en, m_lvl);
        wr_en = 1'b0;
    endtask

    task automatic wr(input int wf, input int slot, input bit vld, input int tk, input int act);
        wr_en = 1'b1; wr_wf = 2'(wf); wr_slot = 2'(slot);
        wr_valid = vld; wr_tick = TICK_W'(tk); wr_act = 2'(act);
        step();
    endtask

    task automatic to_tick(input int t);
        while (m_tc != t) step();
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n * TICKS; i++) step();
    endtask

    initial begin
        void'($urandom(32'h5EED_0123));
        m_tc = 0; m_selq = 0; m_en = 0; m_lvl = 0;
        for (int w = 0; w < NUM_WF; w++)
            for (int e = 0; e < NUM_EV; e++) begin mv[w][e] = 0; mt[w][e] = 0; ma[w][e] = 0; end
        for (int i = 0; i < WR_LAT; i++) pv[i] = 0;

        // R1: reset state, then an empty store keeps the pin undriven.
        repeat (3) @(negedge clk);
        check_out(0, 0);
        rst_n = 1'b1;
        for (int c = 0; c < 2; c++) begin wf_sel = 2'(c + 1); run_cycles(1); end

        // R3 R4 R5: several events per cycle, state carried over the boundary.
        tag = "R3 R4 R5";
        wf_sel = 2'd1;
        wr(1, 0, 1, 2, 2);
        wr(1, 1, 1, 6, 1);
        wr(1, 2, 1, 10, 3);
        wr(1, 3, 1, 13, 2);
        run_cycles(3);

        // R6 R7 R8: collision priority, invalid slot, tick past the cycle.
        tag = "R6 R7 R8";
        wr(2, 0, 1, 4, 2);
        wr(2, 1, 1, 4, 1);
        wr(2, 2, 0, 8, 2);
        wr(2, 3, 1, 20, 2);
        to_tick(TICKS - 1);
        wf_sel = 2'd2;
        run_cycles(2);
        wr(2, 0, 1, 9, 0);
        run_cycles(1);

        // R2: tick 0 selection and ignored mid-cycle selector changes.
        tag = "R2";
        wr(3, 0, 1, 0, 2);
        wr(3, 1, 1, 8, 3);
        wr(0, 0, 1, 0, 1);
        for (int c = 0; c < 4; c++) begin
            to_tick(0);
            wf_sel = (c % 2 == 0) ? 2'd3 : 2'd0;
            step();
            to_tick(5);
            wf_sel = (c % 2 == 0) ? 2'd0 : 2'd3;
        end
        run_cycles(1);

        // R9: write into the running waveform just before its event.
        tag = "R9";
        to_tick(0);
        wf_sel = 2'd1;
        step();
        run_cycles(1);
        to_tick(5);
        wr(1, 1, 1, 7, 1);
        run_cycles(2);

        // R10: pending write to another waveform leaves this one alone.
        tag = "R10";
        to_tick(1);
        wr(2, 1, 1, 3, 3);
        run_cycles(2);

        // Random mix of selections and writes (R3 R9 R10).
        tag = "R3 R9 R10 random";
        for (int c = 0; c < 200; c++) begin
            for (int t = 0; t < TICKS; t++) begin
                if (m_tc == 0 || ($urandom % 8) == 0) wf_sel = 2'($urandom % NUM_WF);
                if (($urandom % 6) == 0)
                    wr(int'($urandom % NUM_WF), int'($urandom % NUM_EV), bit'($urandom % 4 != 0),
                       int'($urandom % 32), int'($urandom % 4));
                else
                    step();
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule